// File: doc/BRIEF.md
# Fault Capture and Scan-out Array

This block sits next to a memory self-test sequencer and records where each detected fault lies, without holding the test up. Whenever the sequencer reports a read mismatch while diagnosis is enabled, the block latches the address under test and the word read back. It shows the most recent pair on parallel outputs and gives a one-cycle fault pulse.

The same pair is also queued for serial unload. A shifter takes one queued record at a time and raises a scan request toward the test logic. A shift counter then walks the record out on a single scan line, one bit for each cycle in which the scan-enable input is high. A small capture buffer absorbs failures that arrive while a record is still being shifted, so the march keeps advancing. If the buffer is already full when another failure arrives, that failure is dropped from the serial path and a sticky overflow flag is set.

The diagnosis-enable input gates all of this. While it is low, mismatches are ignored and the serial path is frozen and silent.

Top module: `fault_scan_array`

## Requirements
- R1: While reset is asserted, fault_addr and fault_data are zero, and fault_pulse, scan_req, scan_out and overflow are all low.
- R2: At a clock edge where diag_en and mismatch are both high, fault_addr takes cur_addr and fault_data takes rd_data, visible from the following cycle.
- R3: fault_addr and fault_data keep their last captured values until the next accepted mismatch.
- R4: fault_pulse is high for exactly the cycle that follows each accepted mismatch, and is low otherwise.
- R5: A mismatch seen while diag_en is low has no effect: fault_addr and fault_data do not change, fault_pulse stays low, and no serial record is produced.
- R6: Each serial record is ADDR_W+DATA_W bits long. It carries the captured address MSB first and then the captured data MSB first. scan_req stays high from the first bit of a record to its last.
- R7: While scan_req is high, the bit on scan_out advances after each clock edge at which both scan_en and diag_en are high. Otherwise it holds. While diag_en is low, scan_req and scan_out are forced low, and shifting resumes on the same bit once diag_en returns.
- R8: Up to two accepted failures can wait behind the record being shifted. Records leave in the order their failures were accepted, and a failure accepted during a shift is not lost.
- R9: A failure accepted while both waiting slots are full is left out of the serial path but still updates fault_addr and fault_data. It also sets overflow, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| diag_en | input | 1 | Diagnosis enable; gates capture and shifting |
| mismatch | input | 1 | Comparator strobe: the read word differs from the expected word |
| cur_addr | input | ADDR_W | Address of the failing read |
| rd_data | input | DATA_W | Word returned by the failing read |
| scan_en | input | 1 | Allows the serial record to advance one bit |
| scan_req | output | 1 | A serial record is being presented |
| scan_out | output | 1 | Serial record bit |
| fault_addr | output | ADDR_W | Most recent captured failing address |
| fault_data | output | DATA_W | Most recent captured failing word |
| fault_pulse | output | 1 | One-cycle pulse per accepted failure |
| overflow | output | 1 | Sticky flag: a failure was dropped from the serial path |

## Verification
The assertions assume that mismatch, cur_addr and rd_data are valid together in one cycle, and that scan_en and diag_en change only between clock edges. Neither input is assumed to follow any pattern with respect to scan_req. The random stimulus lets scan_en and diag_en wander freely. It issues a new failure only while the bench's own count of unfinished records is below two, so no random failure can overflow the buffer. The buffer-full and dropped-record cases come from a separate directed burst with scan_en held low.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_mode_e;

endpackage

// File: rtl/fsa_capture_fifo.sv
module fsa_capture_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_pop, do_push, room;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        room    = (st_q.cnt < DEPTH_C) || do_pop;
        do_push = push && room;
        if (do_pop) begin
            st_d.rp = adv(st_q.rp);
        end
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp           = adv(st_q.wp);
        end
        if (push && !room) begin
            st_d.ovf = 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head      = st_q.mem[st_q.rp];
    assign not_empty = (st_q.cnt != '0);
    assign ovf       = st_q.ovf;

    // R8: occupancy never exceeds the number of slots
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DEPTH_C);

    // R9: overflow is sticky
    p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R9: a push into a full buffer with no pop raises overflow
    p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt == DEPTH_C) |=> ovf);

endmodule

// File: rtl/fsa_shifter.sv
module fsa_shifter
    import fsa_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic         avail,
    input  logic [W-1:0] frame_in,
    output logic         take,
    output logic         busy,
    output logic         sdo
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(W - 1);

    typedef struct packed {
        sh_mode_e      mode;
        logic [W-1:0]  sr;
        logic [CW-1:0] cnt;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = run && (st_q.mode == SH_IDLE) && avail;
        if (take) begin
            st_d.mode = SH_BUSY;
            st_d.sr   = frame_in;
            st_d.cnt  = '0;
        end else if ((st_q.mode == SH_BUSY) && run && step) begin
            st_d.sr  = {st_q.sr[W-2:0], 1'b0};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_C) begin
                st_d.mode = SH_IDLE;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: SH_IDLE, sr: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = run && (st_q.mode == SH_BUSY);
    assign sdo  = busy && st_q.sr[W-1];

    // R7: without run and step a record in flight holds its bit and position
    p_hold_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == SH_BUSY) && !(run && step)) |=> ($stable(st_q.sr) && $stable(st_q.cnt)));

    // R6: a record never starts while another is in flight
    p_single_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SH_BUSY) |-> !take);

endmodule

// File: rtl/fault_scan_array.sv
module fault_scan_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              diag_en,
    input  logic              mismatch,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              scan_en,
    output logic              scan_req,
    output logic              scan_out,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [DATA_W-1:0] fault_data,
    output logic              fault_pulse,
    output logic              overflow
);
    localparam int FW = ADDR_W + DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              pulse;
    } cap_st_t;

    cap_st_t       st_d, st_q;
    logic          capture;
    logic          q_take;
    logic          q_avail;
    logic [FW-1:0] q_head;

    always_comb begin
        st_d       = st_q;
        capture    = diag_en && mismatch;
        st_d.pulse = capture;
        if (capture) begin
            st_d.addr = cur_addr;
            st_d.data = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fsa_capture_fifo #(
        .W     (FW),
        .DEPTH (QDEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (capture),
        .push_data ({cur_addr, rd_data}),
        .pop       (q_take),
        .head      (q_head),
        .not_empty (q_avail),
        .ovf       (overflow)
    );

    fsa_shifter #(
        .W (FW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (diag_en),
        .step     (scan_en),
        .avail    (q_avail),
        .frame_in (q_head),
        .take     (q_take),
        .busy     (scan_req),
        .sdo      (scan_out)
    );

    assign fault_addr  = st_q.addr;
    assign fault_data  = st_q.data;
    assign fault_pulse = st_q.pulse;

    // R4: every pulse follows an accepted mismatch
    p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> $past(diag_en && mismatch));

    // R2: an accepted mismatch lands on the parallel outputs
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_en && mismatch) |=> (fault_addr == $past(cur_addr) && fault_data == $past(rd_data)));

    // R3, R5: without an accepted mismatch the parallel outputs hold
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(diag_en && mismatch) |=> ($stable(fault_addr) && $stable(fault_data)));

    // R7: serial path is silent while diagnosis is off
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_en |-> (!scan_req && !scan_out));

endmodule

// File: tb/tb_fault_scan_array.sv
module tb_fault_scan_array;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int FW = AW + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          diag_en = 1'b0;
    logic          mismatch = 1'b0;
    logic [AW-1:0] cur_addr = '0;
    logic [DW-1:0] rd_data = '0;
    logic          scan_en = 1'b0;
    logic          scan_req, scan_out, fault_pulse, overflow;
    logic [AW-1:0] fault_addr;
    logic [DW-1:0] fault_data;

    int total = 0;
    int bad = 0;
    int pushed = 0;
    int done = 0;
    int nbits = 0;
    logic [FW-1:0] col = '0;
    logic [FW-1:0] exp_q [0:1023];
    logic [AW-1:0] exp_ao = '0;
    logic [DW-1:0] exp_do = '0;
    logic          exp_pulse = 1'b0;

    fault_scan_array #(.ADDR_W(AW), .DATA_W(DW), .QDEPTH(2)) dut (
        .clk(clk), .rst_n(rst_n), .diag_en(diag_en), .mismatch(mismatch),
        .cur_addr(cur_addr), .rd_data(rd_data), .scan_en(scan_en),
        .scan_req(scan_req), .scan_out(scan_out), .fault_addr(fault_addr),
        .fault_data(fault_data), .fault_pulse(fault_pulse), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // serial collector, samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!diag_en && (scan_req || scan_out))
                chk(1'b0, "R7 quiet while disabled", {scan_req, scan_out}, 0);
            if (diag_en && nbits != 0 && !scan_req)
                chk(1'b0, "R6 scan_req dropped mid-record", nbits, FW);
            if (scan_req && scan_en && diag_en) begin
                col = {col[FW-2:0], scan_out};
                nbits++;
                if (nbits == FW) begin
                    if (done < pushed)
                        chk(col == exp_q[done], "R6/R8 record content and order", col, exp_q[done]);
                    else
                        chk(1'b0, "R8 unexpected record", col, 0);
                    done++;
                    nbits = 0;
                end
            end
        end
    end

    // apply inputs for one edge; called just after a rising edge
    task automatic tick(input logic dg, input logic mm, input logic se,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input logic enq);
        diag_en = dg; mismatch = mm; scan_en = se; cur_addr = a; rd_data = d;
        if (dg && mm && enq) begin
            exp_q[pushed] = {a, d};
            pushed++;
        end
        @(posedge clk); #1;
        if (dg && mm) begin
            exp_ao = a; exp_do = d; exp_pulse = 1'b1;
        end else begin
            exp_pulse = 1'b0;
        end
        chk(fault_pulse == exp_pulse, "R4 fault_pulse", fault_pulse, exp_pulse);
        chk(fault_addr == exp_ao, "R2/R3 fault_addr", fault_addr, exp_ao);
        chk(fault_data == exp_do, "R2/R3 fault_data", fault_data, exp_do);
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit && (done < pushed || scan_req); i++)
            tick(1'b1, 1'b0, 1'b1, '0, '0, 1'b0);
        chk(done == pushed, "R8 all records delivered", done, pushed);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h5eed1234));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(fault_addr == 0 && fault_data == 0, "R1 parallel outputs zero", {fault_addr, fault_data}, 0);
        chk(!fault_pulse && !scan_req && !scan_out && !overflow, "R1 flags low",
            {fault_pulse, scan_req, scan_out, overflow}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2/R4/R6 single capture
        tick(1'b1, 1'b1, 1'b0, 8'hA5, 8'h3C, 1'b1);
        tick(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
        chk(fault_addr == 8'hA5, "R3 address held", fault_addr, 8'hA5);
        drain(60);

        // R5 disabled mismatch ignored
        base = done;
        tick(1'b0, 1'b1, 1'b1, 8'h11, 8'h22, 1'b0);
        for (int i = 0; i < 5; i++) begin
            tick(1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
            chk(!scan_req, "R5 no record from ignored mismatch", scan_req, 0);
        end
        chk(fault_addr == 8'hA5 && fault_data == 8'h3C, "R5 parallel unchanged",
            {fault_addr, fault_data}, 16'hA53C);
        chk(done == base, "R5 no extra record", done, base);

        // R7 stalls on scan_en and diag_en mid-record
        tick(1'b1, 1'b1, 1'b0, 8'h96, 8'hE1, 1'b1);
        for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
        for (int i = 0; i < 40; i++)
            tick((i % 3) != 1, 1'b0, (i % 2) == 0, 8'h00, 8'h00, 1'b0);
        drain(60);

        // random phase, failures limited so the buffer cannot fill
        for (int c = 0; c < 4000; c++) begin
            logic dg, mm, se;
            dg = ($urandom % 16) != 0;
            se = ($urandom % 4) != 0;
            mm = (($urandom % 8) == 0) && ((pushed - done) < 2);
            tick(dg, mm, se, AW'($urandom), DW'($urandom), 1'b1);
            if (c % 97 == 0)
                chk(!overflow, "R8 no overflow within buffer limit", overflow, 0);
        end
        drain(400);

        // R9 burst with shifting held off
        tick(1'b1, 1'b1, 1'b0, 8'h01, 8'hF0, 1'b1);
        tick(1'b1, 1'b1, 1'b0, 8'h02, 8'hE0, 1'b1);
        tick(1'b1, 1'b1, 1'b0, 8'h03, 8'hD0, 1'b1);
        chk(!overflow, "R8 two waiting plus one in shift fits", overflow, 0);
        tick(1'b1, 1'b1, 1'b0, 8'h04, 8'hC0, 1'b0);
        chk(overflow, "R9 overflow set on dropped failure", overflow, 1);
        chk(fault_addr == 8'h04 && fault_data == 8'hC0, "R9 dropped failure on parallel outputs",
            {fault_addr, fault_data}, 16'h04C0);
        drain(200);
        chk(overflow, "R9 overflow sticky", overflow, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule